// File: doc/BRIEF.md
# Parallel port handshake controller

This block gives a processor two 8-bit peripheral ports, A and B. Each port has a Ready output and an active-low Strobe input, which pace single-byte transfers with a peripheral. A port can be set up for byte output, byte input or bit mode. Port A can also run a bidirectional byte mode. In that mode port A carries the data in both directions, and port B's handshake pair and interrupt flag serve the input direction.

The processor side is a set of plain strobes. A configuration write sets a port's mode and interrupt enable. There is one data write strobe and one data read strobe for each port. Each port also has an interrupt acknowledge input.

Strobe and pin inputs pass through a synchronizer chain of configurable depth before the block acts on them. A handshake completes on the rising edge of the synchronized Strobe. When it completes, the block sets a sticky interrupt flag, provided interrupts are enabled for that port. The output drivers are controlled by an output-enable signal per port.

Top module: `pport_hs`

## Requirements
- R1: After reset both ports are in byte input mode, with Ready low, output enables low, interrupt flags low and interrupts disabled.
- R2: Mode codes are 0 output, 1 input, 2 bidirectional and 3 bit. In output mode, a data write stores the byte, which appears on the port's pin outputs. Ready and the output enable are high from the next cycle.
- R3: In output mode, Strobe's return to high clears Ready SYNC_STAGES+1 clock edges after the pin changes. Ready then stays low until the next data write.
- R4: In input mode, a data read sets Ready in the next cycle. The read data output shows the input register.
- R5: In input mode, Strobe's return to high loads the pin value present at that edge into the input register and clears Ready, with the same latency as R3.
- R6: A completed handshake sets the port's interrupt flag only while that port's interrupt enable is set. The flag holds until acknowledged. A set in the same cycle as an acknowledge wins.
- R7: In bidirectional mode, port A's output enable follows port A's Strobe being low, with no register in the path. Writes and port A's Strobe run the output handshake on port A's Ready and interrupt flag.
- R8: In bidirectional mode, a read of port A sets port B's Ready. Port B's Strobe loads port A's pins into port A's input register, clears port B's Ready and, under port A's interrupt enable, sets port B's interrupt flag. Port B does not drive its pins.
- R9: In bit mode, Ready and the output enable stay low and Strobes have no effect on the interrupt flag. A bidirectional code written to port B selects bit mode.
- R10: A configuration write (select 0 for A, 1 for B) clears that port's Ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_wr_i | input | 1 | Configuration write strobe |
| cfg_sel_i | input | 1 | Configuration target, 0 port A, 1 port B |
| cfg_mode_i | input | 2 | Mode code |
| cfg_ie_i | input | 1 | Interrupt enable |
| a_wr_i | input | 1 | Port A data write |
| a_rd_i | input | 1 | Port A data read |
| b_wr_i | input | 1 | Port B data write |
| b_rd_i | input | 1 | Port B data read |
| wdata_i | input | DW | Write data |
| a_rdata_o | output | DW | Port A read data |
| b_rdata_o | output | DW | Port B read data |
| a_ack_i | input | 1 | Port A interrupt acknowledge |
| b_ack_i | input | 1 | Port B interrupt acknowledge |
| a_irq_o | output | 1 | Port A interrupt flag |
| b_irq_o | output | 1 | Port B interrupt flag |
| a_pin_i | input | DW | Port A pin input |
| a_pin_o | output | DW | Port A pin output |
| a_oe_o | output | 1 | Port A output enable |
| a_rdy_o | output | 1 | Port A Ready |
| a_stb_ni | input | 1 | Port A Strobe, active low |
| b_pin_i | input | DW | Port B pin input |
| b_pin_o | output | DW | Port B pin output |
| b_oe_o | output | 1 | Port B output enable |
| b_rdy_o | output | 1 | Port B Ready |
| b_stb_ni | input | 1 | Port B Strobe, active low |

## Verification
The bench builds the block with DW=8 and SYNC_STAGES=3, one stage deeper than the default. This exercises the generated synchronizer chain beyond its minimum and makes the handshake latency the bench waits for depend on the parameter. A full byte width lets random data cover every pin value in both directions. The setting also lets the bench line up an acknowledge with a handshake completion in the same cycle.

// File: rtl/pport_pkg.sv
package pport_pkg;
  typedef enum logic [1:0] {
    PM_OUT   = 2'd0,
    PM_IN    = 2'd1,
    PM_BIDIR = 2'd2,
    PM_BIT   = 2'd3
  } pmode_e;
endpackage

// File: rtl/pport_sync.sv
module pport_sync #(
  parameter int unsigned W      = 9,
  parameter int unsigned STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg [STAGES];

  for (genvar i = 0; i < STAGES; i++) begin : g_stg
    if (i == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) stg[i] <= RST_VAL;
        else         stg[i] <= d_i;
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) stg[i] <= RST_VAL;
        else         stg[i] <= stg[i-1];
    end
  end

  assign q_o = stg[STAGES-1];
endmodule

// File: rtl/pport_chan.sv
module pport_chan
  import pport_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  pmode_e        mode_i,
  input  logic          cfg_i,
  input  logic          wr_i,
  input  logic          rd_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [DW-1:0] pin_i,
  input  logic          out_rise_i,
  input  logic          in_rise_i,
  output logic [DW-1:0] out_q_o,
  output logic [DW-1:0] in_q_o,
  output logic          out_rdy_o,
  output logic          in_rdy_o,
  output logic          out_done_o,
  output logic          in_done_o
);
  logic use_out, use_in;

  assign use_out = (mode_i == PM_OUT) || (mode_i == PM_BIDIR);
  assign use_in  = (mode_i == PM_IN)  || (mode_i == PM_BIDIR);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_q_o   <= '0;
      in_q_o    <= '0;
      out_rdy_o <= 1'b0;
      in_rdy_o  <= 1'b0;
    end else begin
      if (wr_i) out_q_o <= wdata_i;
      if (use_in && in_rise_i) in_q_o <= pin_i;
      // write beats a coincident strobe: new data must not be lost
      if (!use_out || cfg_i) out_rdy_o <= 1'b0;
      else if (wr_i)         out_rdy_o <= 1'b1;
      else if (out_rise_i)   out_rdy_o <= 1'b0;
      if (!use_in || cfg_i)  in_rdy_o <= 1'b0;
      else if (rd_i)         in_rdy_o <= 1'b1;
      else if (in_rise_i)    in_rdy_o <= 1'b0;
    end
  end

  assign out_done_o = use_out && out_rise_i;
  assign in_done_o  = use_in && in_rise_i;
endmodule

// File: rtl/pport_irq.sv
module pport_irq (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic ack_i,
  output logic q_o
);
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)    q_o <= 1'b0;
    else if (set_i) q_o <= 1'b1;
    else if (ack_i) q_o <= 1'b0;
endmodule

// File: rtl/pport_hs.sv
module pport_hs
  import pport_pkg::*;
#(
  parameter int unsigned DW          = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cfg_wr_i,
  input  logic          cfg_sel_i,
  input  logic [1:0]    cfg_mode_i,
  input  logic          cfg_ie_i,
  input  logic          a_wr_i,
  input  logic          a_rd_i,
  input  logic          b_wr_i,
  input  logic          b_rd_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] a_rdata_o,
  output logic [DW-1:0] b_rdata_o,
  input  logic          a_ack_i,
  input  logic          b_ack_i,
  output logic          a_irq_o,
  output logic          b_irq_o,
  input  logic [DW-1:0] a_pin_i,
  output logic [DW-1:0] a_pin_o,
  output logic          a_oe_o,
  output logic          a_rdy_o,
  input  logic          a_stb_ni,
  input  logic [DW-1:0] b_pin_i,
  output logic [DW-1:0] b_pin_o,
  output logic          b_oe_o,
  output logic          b_rdy_o,
  input  logic          b_stb_ni
);
  localparam int unsigned SW = DW + 1;
  localparam logic [SW-1:0] SYNC_RST = {1'b1, {DW{1'b0}}};

  pmode_e a_mode_q, b_mode_q, b_mode_eff;
  logic   a_ie_q, b_ie_q, a_bidir, a_cfg, b_cfg;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      a_mode_q <= PM_IN;
      b_mode_q <= PM_IN;
      a_ie_q   <= 1'b0;
      b_ie_q   <= 1'b0;
    end else if (cfg_wr_i) begin
      if (!cfg_sel_i) begin
        a_mode_q <= pmode_e'(cfg_mode_i);
        a_ie_q   <= cfg_ie_i;
      end else begin
        // port B has no bidirectional mode
        b_mode_q <= (pmode_e'(cfg_mode_i) == PM_BIDIR) ? PM_BIT : pmode_e'(cfg_mode_i);
        b_ie_q   <= cfg_ie_i;
      end
    end
  end

  assign a_cfg      = cfg_wr_i && !cfg_sel_i;
  assign b_cfg      = cfg_wr_i && cfg_sel_i;
  assign a_bidir    = (a_mode_q == PM_BIDIR);
  assign b_mode_eff = a_bidir ? PM_BIT : b_mode_q;

  logic [SW-1:0] a_sync, b_sync;
  logic          a_stb_p, b_stb_p, a_rise, b_rise;

  pport_sync #(.W(SW), .STAGES(SYNC_STAGES), .RST_VAL(SYNC_RST)) i_sync_a (
    .clk_i, .rst_ni, .d_i({a_stb_ni, a_pin_i}), .q_o(a_sync));
  pport_sync #(.W(SW), .STAGES(SYNC_STAGES), .RST_VAL(SYNC_RST)) i_sync_b (
    .clk_i, .rst_ni, .d_i({b_stb_ni, b_pin_i}), .q_o(b_sync));

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      a_stb_p <= 1'b1;
      b_stb_p <= 1'b1;
    end else begin
      a_stb_p <= a_sync[DW];
      b_stb_p <= b_sync[DW];
    end

  assign a_rise = a_sync[DW] && !a_stb_p;
  assign b_rise = b_sync[DW] && !b_stb_p;

  logic [DW-1:0] a_out_q, a_in_q, b_out_q, b_in_q;
  logic a_out_rdy, a_in_rdy, a_out_done, a_in_done;
  logic b_out_rdy, b_in_rdy, b_out_done, b_in_done;

  pport_chan #(.DW(DW)) i_chan_a (
    .clk_i, .rst_ni,
    .mode_i(a_mode_q), .cfg_i(a_cfg), .wr_i(a_wr_i), .rd_i(a_rd_i),
    .wdata_i, .pin_i(a_sync[DW-1:0]),
    .out_rise_i(a_rise), .in_rise_i(a_bidir ? b_rise : a_rise),
    .out_q_o(a_out_q), .in_q_o(a_in_q),
    .out_rdy_o(a_out_rdy), .in_rdy_o(a_in_rdy),
    .out_done_o(a_out_done), .in_done_o(a_in_done));

  pport_chan #(.DW(DW)) i_chan_b (
    .clk_i, .rst_ni,
    .mode_i(b_mode_eff), .cfg_i(b_cfg), .wr_i(b_wr_i), .rd_i(b_rd_i),
    .wdata_i, .pin_i(b_sync[DW-1:0]),
    .out_rise_i(b_rise), .in_rise_i(b_rise),
    .out_q_o(b_out_q), .in_q_o(b_in_q),
    .out_rdy_o(b_out_rdy), .in_rdy_o(b_in_rdy),
    .out_done_o(b_out_done), .in_done_o(b_in_done));

  logic a_irq_set, b_irq_set;
  assign a_irq_set = a_ie_q && (a_out_done || (a_in_done && !a_bidir));
  assign b_irq_set = (b_ie_q && (b_out_done || b_in_done)) ||
                     (a_ie_q && a_bidir && a_in_done);

  pport_irq i_irq_a (.clk_i, .rst_ni, .set_i(a_irq_set), .ack_i(a_ack_i), .q_o(a_irq_o));
  pport_irq i_irq_b (.clk_i, .rst_ni, .set_i(b_irq_set), .ack_i(b_ack_i), .q_o(b_irq_o));

  assign a_pin_o   = a_out_q;
  assign b_pin_o   = b_out_q;
  // bus turnaround follows the raw strobe
  assign a_oe_o    = (a_mode_q == PM_OUT) || (a_bidir && !a_stb_ni);
  assign b_oe_o    = (b_mode_eff == PM_OUT);
  assign a_rdy_o   = a_out_rdy || (a_in_rdy && !a_bidir);
  assign b_rdy_o   = a_bidir ? a_in_rdy : (b_out_rdy || b_in_rdy);
  assign a_rdata_o = (a_mode_q == PM_OUT) ? a_out_q : a_in_q;
  assign b_rdata_o = (b_mode_eff == PM_OUT) ? b_out_q : b_in_q;
endmodule

// File: rtl/pport_hs_chk.sv
module pport_hs_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       cfg_wr_i,
  input logic       a_wr_i,
  input logic       a_rd_i,
  input logic       a_ack_i,
  input logic       b_ack_i,
  input logic       a_stb_ni,
  input logic [1:0] a_mode,
  input logic       a_rdy_o,
  input logic       a_oe_o,
  input logic       a_irq_o,
  input logic       b_oe_o,
  input logic       b_irq_o
);
  // R2
  wr_rdy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (a_wr_i && a_mode == 2'd0 && !cfg_wr_i) |=> a_rdy_o);
  // R4
  rd_rdy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (a_rd_i && a_mode == 2'd1 && !cfg_wr_i) |=> a_rdy_o);
  // R6
  irq_a_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (a_irq_o && !a_ack_i) |=> a_irq_o);
  // R6
  irq_b_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (b_irq_o && !b_ack_i) |=> b_irq_o);
  // R7
  bidir_oe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (a_mode == 2'd2 && a_stb_ni) |-> !a_oe_o);
  // R8
  bidir_b_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (a_mode == 2'd2) |-> !b_oe_o);
  // R9
  bit_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (a_mode == 2'd3) |-> (!a_rdy_o && !a_oe_o));
endmodule

bind pport_hs pport_hs_chk i_pport_hs_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .cfg_wr_i(cfg_wr_i),
  .a_wr_i(a_wr_i), .a_rd_i(a_rd_i), .a_ack_i(a_ack_i), .b_ack_i(b_ack_i),
  .a_stb_ni(a_stb_ni), .a_mode(a_mode_q),
  .a_rdy_o(a_rdy_o), .a_oe_o(a_oe_o), .a_irq_o(a_irq_o),
  .b_oe_o(b_oe_o), .b_irq_o(b_irq_o));

// File: tb/test_pport_hs.sv
module test_pport_hs;
  localparam int DW   = 8;
  localparam int SYNC = 3;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic cfg_wr_i = 0, cfg_sel_i = 0, cfg_ie_i = 0;
  logic [1:0] cfg_mode_i = 0;
  logic a_wr_i = 0, a_rd_i = 0, b_wr_i = 0, b_rd_i = 0;
  logic [DW-1:0] wdata_i = 0, a_pin_i = 0, b_pin_i = 0;
  logic a_ack_i = 0, b_ack_i = 0, a_stb_ni = 1, b_stb_ni = 1;
  logic [DW-1:0] a_rdata_o, b_rdata_o, a_pin_o, b_pin_o;
  logic a_irq_o, b_irq_o, a_oe_o, b_oe_o, a_rdy_o, b_rdy_o;

  int total = 0, bad = 0;
  bit finished = 0;

  always #4 clk_i = ~clk_i;

  pport_hs #(.DW(DW), .SYNC_STAGES(SYNC)) i_pport_hs (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  function automatic logic exp_irq(input logic ie, input logic prev);
    return ie | prev;
  endfunction

  task automatic cfg(input logic sel, input logic [1:0] mode, input logic ie);
    @(negedge clk_i);
    cfg_wr_i = 1; cfg_sel_i = sel; cfg_mode_i = mode; cfg_ie_i = ie;
    @(negedge clk_i);
    cfg_wr_i = 0;
  endtask

  task automatic wr(input logic sel, input logic [DW-1:0] d);
    @(negedge clk_i);
    wdata_i = d; a_wr_i = !sel; b_wr_i = sel;
    @(negedge clk_i);
    a_wr_i = 0; b_wr_i = 0;
  endtask

  task automatic rd(input logic sel);
    @(negedge clk_i);
    a_rd_i = !sel; b_rd_i = sel;
    @(negedge clk_i);
    a_rd_i = 0; b_rd_i = 0;
  endtask

  task automatic ack(input logic sel);
    @(negedge clk_i);
    a_ack_i = !sel; b_ack_i = sel;
    @(negedge clk_i);
    a_ack_i = 0; b_ack_i = 0;
  endtask

  // strobe low then high; returns at the negedge after the effect edge
  task automatic stb(input logic sel);
    @(negedge clk_i);
    if (sel) b_stb_ni = 0; else a_stb_ni = 0;
    repeat (3) @(negedge clk_i);
    if (sel) b_stb_ni = 1; else a_stb_ni = 1;
    repeat (SYNC + 1) @(posedge clk_i);
    @(negedge clk_i);
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog act=1 exp=0");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [DW-1:0] d, d2;
    logic sel;
    void'($urandom(32'd17));
    repeat (3) @(negedge clk_i);
    // R1
    chk("R1 rdy", {a_rdy_o, b_rdy_o}, 0);
    chk("R1 oe", {a_oe_o, b_oe_o}, 0);
    chk("R1 irq", {a_irq_o, b_irq_o}, 0);
    rst_ni = 1;
    stb(0);
    chk("R1 ie off", a_irq_o, 0);

    // R2 R3 R6 output on A
    cfg(0, 2'd0, 1);
    wr(0, 8'hA5);
    chk("R2 rdy", a_rdy_o, 1);
    chk("R2 pin", a_pin_o, 8'hA5);
    chk("R2 oe", a_oe_o, 1);
    stb(0);
    chk("R3 rdy clr", a_rdy_o, 0);
    chk("R6 irq set", a_irq_o, 1);
    repeat (4) @(negedge clk_i);
    chk("R3 rdy low", a_rdy_o, 0);
    // R6 set wins over coincident ack
    wr(0, 8'h11);
    @(negedge clk_i); a_stb_ni = 0;
    repeat (3) @(negedge clk_i); a_stb_ni = 1;
    repeat (SYNC) @(posedge clk_i);
    @(negedge clk_i); a_ack_i = 1;
    @(negedge clk_i); a_ack_i = 0;
    chk("R6 set beats ack", a_irq_o, 1);
    ack(0);
    chk("R6 ack", a_irq_o, 0);
    // R10
    wr(0, 8'h22);
    cfg(0, 2'd0, 0);
    chk("R10 cfg clears", a_rdy_o, 0);
    wr(0, 8'h33);
    stb(0);
    chk("R6 ie off", a_irq_o, exp_irq(0, 0));

    // R4 R5 input on B
    cfg(1, 2'd1, 1);
    chk("R4 rdy idle", b_rdy_o, 0);
    rd(1);
    chk("R4 rdy", b_rdy_o, 1);
    b_pin_i = 8'h3C;
    @(negedge clk_i); b_stb_ni = 0;
    b_pin_i = 8'hC3;
    repeat (4) @(negedge clk_i); b_stb_ni = 1;
    repeat (SYNC + 1) @(posedge clk_i);
    @(negedge clk_i);
    chk("R5 data", b_rdata_o, 8'hC3);
    chk("R5 rdy clr", b_rdy_o, 0);
    chk("R6 b irq", b_irq_o, 1);
    ack(1);

    // R7 R8 bidirectional on A
    cfg(1, 2'd3, 0);
    cfg(0, 2'd2, 1);
    chk("R7 oe off", a_oe_o, 0);
    @(negedge clk_i); a_stb_ni = 0; #1;
    chk("R7 oe on", a_oe_o, 1);
    a_stb_ni = 1; #1;
    chk("R7 oe off2", a_oe_o, 0);
    wr(0, 8'h5A);
    chk("R7 rdy", a_rdy_o, 1);
    stb(0);
    chk("R7 rdy clr", a_rdy_o, 0);
    chk("R7 a irq", a_irq_o, 1);
    ack(0);
    rd(0);
    chk("R8 b rdy", b_rdy_o, 1);
    chk("R8 b oe", b_oe_o, 0);
    a_pin_i = 8'h96;
    stb(1);
    chk("R8 data", a_rdata_o, 8'h96);
    chk("R8 b rdy clr", b_rdy_o, 0);
    chk("R8 b irq", b_irq_o, 1);
    chk("R8 a irq", a_irq_o, 0);
    ack(1);

    // R9 bit mode
    cfg(0, 2'd3, 1);
    wr(0, 8'h44);
    chk("R9 rdy", a_rdy_o, 0);
    chk("R9 oe", a_oe_o, 0);
    stb(0);
    chk("R9 irq", a_irq_o, 0);
    cfg(1, 2'd2, 1);
    wr(1, 8'h55);
    chk("R9 b as bit rdy", b_rdy_o, 0);
    chk("R9 b as bit oe", b_oe_o, 0);
    stb(1);
    chk("R9 b irq", b_irq_o, 0);

    // random transfers
    for (int i = 0; i < 40; i++) begin
      sel = 1'($urandom);
      d   = 8'($urandom);
      d2  = 8'($urandom);
      if ($urandom % 2) begin
        cfg(sel, 2'd0, 1);
        wr(sel, d);
        chk("R2 rnd pin", sel ? b_pin_o : a_pin_o, d);
        stb(sel);
        chk("R3 rnd rdy", sel ? b_rdy_o : a_rdy_o, 0);
        chk("R6 rnd irq", sel ? b_irq_o : a_irq_o, 1);
      end else begin
        cfg(sel, 2'd1, 1);
        rd(sel);
        chk("R4 rnd rdy", sel ? b_rdy_o : a_rdy_o, 1);
        if (sel) b_pin_i = d2; else a_pin_i = d2;
        stb(sel);
        chk("R5 rnd data", sel ? b_rdata_o : a_rdata_o, d2);
        chk("R5 rnd rdy", sel ? b_rdy_o : a_rdy_o, 0);
      end
      ack(sel);
      chk("R6 rnd ack", sel ? b_irq_o : a_irq_o, 0);
    end

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule